// File: doc/BRIEF.md
# Three-Mode General-Purpose Timer

This block is a counter-based peripheral timer with a single pin, split into an input path and an output path with an output-enable. One counter datapath is shared by three modes. In waveform mode the pin is an output that carries a repeating pulse. In capture mode the pin is an input, and the block measures both the spacing of its asserting edges and how long it stays asserted. In watchdog mode the pin is an input whose edges must keep arriving, or the timer raises an interrupt.

Software loads a 6-bit configuration word, a period value, a width value and the count through separate write strobes. The current values of all four can be read on output ports at all times. The enable comes from one bit of a control word that is shared with other timers; decoding that word happens outside this block. In capture mode the block writes its measurements back into the period and width registers. The interrupt is a one-cycle pulse.

Top module: `gp_timer`

## Requirements
- R1: The configuration word holds the mode in bits [1:0] (00 off, 01 waveform, 10 capture, 11 watchdog), the pulse polarity in bit 2 (0 means active-high) and the interrupt enable in bit 3. Bits [5:4] always read back as zero, whatever was written to them.
- R2: In the cycle after enable goes from 0 to 1, the count reads zero. While enable is low, the count holds its value, irq stays low and the output pin rests at its inactive level.
- R3: pin_oe is high in waveform mode and low in the other modes.
- R4: In waveform mode with period P, the count steps 0, 1, …, P-1 and then returns to 0. A period of 0 or 1 behaves as 1. irq pulses for one cycle whenever the count has just returned to 0 after a wrap.
- R5: In waveform mode the pin is at its active level while the count is below the width W. This means W = 0 never asserts it, and W ≥ P asserts it for the whole period.
- R6: In capture mode, each asserting edge loads into the period register the number of cycles since the previous asserting edge, restarts the count from zero and pulses irq.
- R7: In capture mode, each deasserting edge loads into the width register the number of cycles the pin was asserted.
- R8: In watchdog mode, any pin edge reloads the count from the period register, and the count then decrements once per cycle. When it steps from 1 to 0, irq pulses once. The count then stays at zero, with no further interrupt, until the next edge.
- R9: The pin input passes through a two-stage synchronizer. A change on the pin takes effect on the count at the third rising clock edge after the change.
- R10: irq never pulses while the interrupt-enable bit is clear.
- R11: Writes to the count, period and width registers show in the next cycle. An enable rise in the same cycle as a count write wins, and the count reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | This timer's bit of the shared control word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 32 | Period write data |
| wid_wr | input | 1 | Width write strobe |
| wid_wdata | input | 32 | Width write data |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write data |
| cfg_q | output | 6 | Configuration readback |
| per_q | output | 32 | Period readback |
| wid_q | output | 32 | Width readback |
| cnt_q | output | 32 | Count readback |
| pin_i | input | 1 | Pin input level |
| pin_o | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Count, irq and pin_o are all registered off the same edge. The bench therefore treats the edge that sees enable rise as step zero and compares count, pin level and irq against step mod P at every later falling edge. A pin change driven before edge X reaches the count only at edge X+2, because of the synchronizer and the edge detector. The watchdog checks therefore wait three falling edges after each toggle before expecting the reload value, and then step the countdown one cycle at a time. Capture results are read only after a few settling cycles past the last pulse of a train, and irq pulses are counted at falling edges over the whole train.

// File: rtl/gpt_pkg.sv
// Shared types for the general-purpose timer.
// Assumes the configuration word is six bits wide, with the top two bits reserved.
package gpt_pkg;

    localparam int CFG_W = 6;
    localparam logic [CFG_W-1:0] CFG_MASK = 6'h0F;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_WAVE = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_WDOG = 2'b11
    } gpt_mode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       irq_en;
        logic       pol;
        gpt_mode_e  mode;
    } gpt_cfg_t;

endpackage

// File: rtl/gpt_insync.sv
// Pin input synchronizer with edge detection.
// Assumes pin_i is asynchronous to clk. rise and fall are single-cycle
// strobes that appear STAGES+1 edges after the pin changes.
module gpt_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // First synchronizer stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
    end

    // Remaining synchronizer stages form a shift chain.
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    endgenerate

    // Previous synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/gpt_regs.sv
// Software-visible configuration, period and width registers.
// Assumes a hardware capture load and a software write in the same
// cycle resolve in favour of the capture.
module gpt_regs import gpt_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             wid_wr,
    input  logic [CNT_W-1:0] wid_wdata,
    input  logic             cap_per_ld,
    input  logic             cap_wid_ld,
    input  logic [CNT_W-1:0] cap_val,
    output gpt_cfg_t         cfg_q,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] wid_q
);

    // Configuration register; reserved bits are masked to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= gpt_cfg_t'(cfg_wdata & CFG_MASK);
    end

    // Period register: a capture load overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          per_q <= '0;
        else if (cap_per_ld) per_q <= cap_val;
        else if (per_wr)     per_q <= per_wdata;
    end

    // Width register: a capture load overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          wid_q <= '0;
        else if (cap_wid_ld) wid_q <= cap_val;
        else if (wid_wr)     wid_q <= wid_wdata;
    end

endmodule

// File: rtl/gpt_counter.sv
// Shared count datapath for waveform, capture and watchdog modes.
// Assumes in_rise/in_fall are synchronized single-cycle strobes.
// Priority per cycle: enable rise, then software count write, then the mode update.
module gpt_counter import gpt_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  gpt_mode_e        mode,
    input  logic             pol,
    input  logic             ie,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] per_q,
    input  logic [CNT_W-1:0] wid_q,
    input  logic             in_rise,
    input  logic             in_fall,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq,
    output logic             drive_active,
    output logic             cap_per_ld,
    output logic             cap_wid_ld,
    output logic [CNT_W-1:0] cap_val
);

    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W:0]   ONE_X = (CNT_W+1)'(1);

    logic en_q;
    logic start;
    logic running;
    logic wrap;
    logic act_rise;
    logic act_fall;
    logic any_edge;
    logic upd;

    assign start    = enable & ~en_q;
    assign running  = enable & en_q;
    assign upd      = running & ~cnt_wr;
    assign wrap     = ({1'b0, cnt_q} + ONE_X) >= {1'b0, per_q};
    assign act_rise = pol ? in_fall : in_rise;
    assign act_fall = pol ? in_rise : in_fall;
    assign any_edge = in_rise | in_fall;

    assign drive_active = running && (mode == MODE_WAVE) && (cnt_q < wid_q);
    assign cap_val      = cnt_q + ONE;
    assign cap_per_ld   = upd && (mode == MODE_CAP) && act_rise;
    assign cap_wid_ld   = upd && (mode == MODE_CAP) && act_fall;

    // Registered copy of enable, used to detect a start.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Count and interrupt update for each mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                cnt_q <= '0;
            end else if (cnt_wr) begin
                cnt_q <= cnt_wdata;
            end else if (running) begin
                case (mode)
                    MODE_WAVE: begin
                        if (wrap) begin
                            cnt_q <= '0;
                            irq   <= ie;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    MODE_CAP: begin
                        if (act_rise) begin
                            cnt_q <= '0;
                            irq   <= ie;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    MODE_WDOG: begin
                        if (any_edge) begin
                            cnt_q <= per_q;
                        end else if (cnt_q == ONE) begin
                            cnt_q <= '0;
                            irq   <= ie;
                        end else if (cnt_q != '0) begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    // R2: an enable rise leaves the count at zero one cycle later.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (cnt_q == '0));

    // R4: a waveform interrupt only ever coincides with a wrapped count.
    a_r4_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(running && mode == MODE_WAVE)) |-> (cnt_q == '0));

    // R6: an asserting capture edge restarts the count and raises irq when enabled.
    a_r6_cap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == MODE_CAP && act_rise && !cnt_wr) |=> (cnt_q == '0 && irq == $past(ie)));

    // R8: an expired watchdog stays at zero with no edge.
    a_r8_expired_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode == MODE_WDOG && cnt_q == '0 && !any_edge && !cnt_wr) |=> (cnt_q == '0 && !irq));

endmodule

// File: rtl/gp_timer.sv
// Three-mode general-purpose timer top level.
// Assumes register writes arrive as per-register strobes and that the pin
// is split into input, output and output-enable at the pad.
module gp_timer import gpt_pkg::*; #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             wid_wr,
    input  logic [CNT_W-1:0] wid_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] wid_q,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    gpt_cfg_t         cfg;
    logic             in_rise;
    logic             in_fall;
    logic             drive_active;
    logic             cap_per_ld;
    logic             cap_wid_ld;
    logic [CNT_W-1:0] cap_val;

    gpt_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .rise  (in_rise),
        .fall  (in_fall)
    );

    gpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .wid_wr     (wid_wr),
        .wid_wdata  (wid_wdata),
        .cap_per_ld (cap_per_ld),
        .cap_wid_ld (cap_wid_ld),
        .cap_val    (cap_val),
        .cfg_q      (cfg),
        .per_q      (per_q),
        .wid_q      (wid_q)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .mode         (cfg.mode),
        .pol          (cfg.pol),
        .ie           (cfg.irq_en),
        .cnt_wr       (cnt_wr),
        .cnt_wdata    (cnt_wdata),
        .per_q        (per_q),
        .wid_q        (wid_q),
        .in_rise      (in_rise),
        .in_fall      (in_fall),
        .cnt_q        (cnt_q),
        .irq          (irq),
        .drive_active (drive_active),
        .cap_per_ld   (cap_per_ld),
        .cap_wid_ld   (cap_wid_ld),
        .cap_val      (cap_val)
    );

    // Pin direction follows the mode; the level follows the polarity.
    assign cfg_q  = cfg;
    assign pin_oe = (cfg.mode == MODE_WAVE);
    assign pin_o  = drive_active ^ cfg.pol;

    // R7: a deasserting capture edge leaves the elapsed count plus one in the width register.
    a_r7_width_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wid_ld |=> (wid_q == $past(cnt_q) + ONE));

    // R5: with the output driven, the active level only appears while the count is below width.
    a_r5_active_below_width: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && (pin_o != cfg.pol)) |-> (cnt_q < wid_q));

endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        cfg_wr;
    logic [5:0]  cfg_wdata;
    logic        per_wr;
    logic [31:0] per_wdata;
    logic        wid_wr;
    logic [31:0] wid_wdata;
    logic        cnt_wr;
    logic [31:0] cnt_wdata;
    logic [5:0]  cfg_q;
    logic [31:0] per_q;
    logic [31:0] wid_q;
    logic [31:0] cnt_q;
    logic        pin_i;
    logic        pin_o;
    logic        pin_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gp_timer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .wid_wr(wid_wr), .wid_wdata(wid_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cfg_q(cfg_q), .per_q(per_q), .wid_q(wid_q), .cnt_q(cnt_q),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
    );

    always @(negedge clk) if (irq === 1'b1) irq_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Load configuration, period and width with enable low.
    task automatic setup(input logic [5:0] c, input logic [31:0] p, input logic [31:0] w);
        @(negedge clk);
        enable = 1'b0;
        cfg_wr = 1'b1; cfg_wdata = c;
        per_wr = 1'b1; per_wdata = p;
        wid_wr = 1'b1; wid_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0; per_wr = 1'b0; wid_wr = 1'b0;
    endtask

    // R4/R5/R10: waveform sequence from the enable rise.
    task automatic run_wave(input int p, input int w, input bit pol, input bit ie);
        int pe;
        logic [31:0] hold;
        pe = (p < 2) ? 1 : p;
        setup({2'b00, ie, pol, 2'b01}, p, w);
        chk("R3 oe in waveform", {31'd0, pin_oe}, 32'd1);
        chk("R2 idle pin level", {31'd0, pin_o}, {31'd0, pol});
        enable = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 2 * pe + 3; j++) begin
            chk("R4 count", cnt_q, j % pe);
            chk("R5 pin level", {31'd0, pin_o}, {31'd0, ((j % pe) < w) ^ pol});
            chk("R4 R10 irq", {31'd0, irq}, {31'd0, ie && j > 0 && (j % pe) == 0});
            @(negedge clk);
        end
        hold = cnt_q;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 count holds while disabled", cnt_q, hold);
        chk("R2 irq low while disabled", {31'd0, irq}, 32'd0);
        chk("R2 pin inactive while disabled", {31'd0, pin_o}, {31'd0, pol});
    endtask

    // R6/R7: capture a pulse train of period d, high time h.
    task automatic run_cap(input int d, input int h, input bit pol);
        int base;
        pin_i = pol;
        setup({2'b00, 1'b1, pol, 2'b10}, 32'd999, 32'd999);
        chk("R3 oe in capture", {31'd0, pin_oe}, 32'd0);
        repeat (4) @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        base = irq_seen;
        for (int n = 0; n < 4; n++) begin
            pin_i = ~pol;
            repeat (h) @(negedge clk);
            pin_i = pol;
            repeat (d - h) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk("R6 period captured", per_q, d);
        chk("R7 width captured", wid_q, h);
        chk("R6 irq per asserting edge", irq_seen - base, 4);
        enable = 1'b0;
    endtask

    // R8/R9: watchdog countdown, expiry, hold and reload.
    task automatic run_wdog(input int p, input bit ie);
        pin_i = 1'b0;
        setup({2'b00, ie, 1'b0, 2'b11}, p, 32'd0);
        chk("R3 oe in watchdog", {31'd0, pin_oe}, 32'd0);
        repeat (4) @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 unarmed count stays zero", cnt_q, 0);
            chk("R8 unarmed no irq", {31'd0, irq}, 32'd0);
        end
        pin_i = ~pin_i;
        repeat (2) @(negedge clk);
        chk("R9 no reload before third edge", cnt_q, 0);
        @(negedge clk);
        for (int k = 0; k < p + 3; k++) begin
            chk("R8 R9 countdown", cnt_q, (k <= p) ? p - k : 0);
            chk("R8 R10 expiry irq", {31'd0, irq}, {31'd0, ie && k == p});
            @(negedge clk);
        end
        pin_i = ~pin_i;
        repeat (3) @(negedge clk);
        chk("R8 reload", cnt_q, p);
        @(negedge clk);
        pin_i = ~pin_i;
        repeat (3) @(negedge clk);
        chk("R8 reload mid-countdown", cnt_q, p);
        enable = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; pin_i = 1'b0;
        cfg_wr = 1'b0; cfg_wdata = '0; per_wr = 1'b0; per_wdata = '0;
        wid_wr = 1'b0; wid_wdata = '0; cnt_wr = 1'b0; cnt_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset count", cnt_q, 0);
        chk("R1 reset cfg", {26'd0, cfg_q}, 0);
        chk("R2 reset irq", {31'd0, irq}, 0);
        chk("R3 reset oe", {31'd0, pin_oe}, 0);

        // R1: reserved bits read as zero.
        setup(6'h3F, 32'd17, 32'd9);
        chk("R1 reserved bits masked", {26'd0, cfg_q}, 32'h0F);
        chk("R11 period write", per_q, 17);
        chk("R11 width write", wid_q, 9);

        // R11: count write, and enable rise winning over it.
        cnt_wr = 1'b1; cnt_wdata = 32'd77;
        @(negedge clk);
        cnt_wr = 1'b0;
        chk("R11 count write", cnt_q, 77);
        cnt_wr = 1'b1; cnt_wdata = 32'd55; enable = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0; enable = 1'b0;
        chk("R11 start beats count write", cnt_q, 0);

        for (int p = 0; p <= 6; p++)
            for (int w = 0; w <= 7; w++)
                for (int pol = 0; pol < 2; pol++)
                    run_wave(p, w, pol[0], (p + w) % 2 == 0);

        for (int d = 2; d <= 6; d++)
            for (int h = 1; h < d; h++)
                for (int pol = 0; pol < 2; pol++)
                    run_cap(d, h, pol[0]);

        for (int p = 1; p <= 5; p++)
            for (int ie = 0; ie < 2; ie++)
                run_wdog(p, ie[0]);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule